// File: doc/BRIEF.md
# Multi-Width Integer ALU with Status Flags

This block is the arithmetic and logic stage of an integer datapath. It takes two 32-bit operands, a three-bit operation code, a carry-in bit and a two-bit operand-size select. From these it produces a result at the chosen width, 8, 16 or 32 bits, at once in the same cycle. The size is picked separately for each operation. Result bits above the chosen width always read as zero.

Each operation also computes six status flags: carry, overflow, sign, zero, auxiliary carry and parity. They land in a registered 32-bit flags word, which loads on the clock edge where the update enable is high. Carry, overflow, sign and zero follow the selected width. Auxiliary carry always comes from bit 3 and parity always from the low byte, whatever the width. A compare changes the flags exactly as a subtract does, but it drops the result-write strobe so that the caller keeps its destination.

Top module: `mw_alu_flags`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR and 7 XOR. Size codes are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Add returns a+b and add-with-carry returns a+b+cin, both computed at the selected width. Result bits above that width are 0.
- R2: Subtract and compare return a-b, and subtract-with-borrow returns a-b-cin, all computed at the selected width. The result-write strobe is 0 for compare and 1 for every other operation code.
- R3: Flags bit 0 (carry) is set when an addition carries out of the top bit of the selected width, or when a subtraction borrows into it.
- R4: Flags bit 11 (overflow) is set when the carry into the sign bit of the selected width differs from the carry out of that bit.
- R5: Flags bit 7 (sign) equals the top result bit at the selected width. Flags bit 6 (zero) is set only when the result at the selected width is all zero.
- R6: Flags bit 4 (auxiliary) is set on a carry out of bit 3 for an addition, or a borrow into bit 3 for a subtraction, for every width.
- R7: Flags bit 2 (parity) is set when result bits 7..0 hold an even number of ones. Higher bits have no effect on it.
- R8: AND, OR and XOR return the bitwise result at the selected width. They clear carry and overflow, set sign, zero and parity from the result, and leave auxiliary unchanged.
- R9: Synchronous reset loads the flags word with 0x00000002. Bit 1 always reads 1, and bits other than 0, 1, 2, 4, 6, 7 and 11 always read 0.
- R10: With the update enable low, the flags word keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_in_i | input | 1 | Carry or borrow for the with-carry forms |
| upd_i | input | 1 | Flags update enable |
| result_o | output | 32 | Result, zero above the selected width |
| res_we_o | output | 1 | Result-write strobe, low for compare |
| flags_o | output | 32 | Registered flags word |

## Verification
The result and the write strobe come from combinational logic. The bench therefore samples them in the same cycle the operands are applied, one time step after it drives them on the falling edge. The flags belong to the rising edge that sees the update enable high, so they are due one clock after the operation is applied. The reference model holds its flags word back until that edge and compares it at the next falling edge. At that edge it checks carry, overflow, sign, zero, auxiliary, parity and the fixed bits separately. A dropped update would show as a difference one cycle later.

// File: rtl/mwalu_pkg.sv
package mwalu_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBB = 3'd3,
      OP_CMP = 3'd4,
      OP_AND = 3'd5,
      OP_OR  = 3'd6,
      OP_XOR = 3'd7
   } alu_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } op_size_e;

   localparam int NUM_LANES   = 3;
   localparam int FLAG_CF     = 0;
   localparam int FLAG_ONE    = 1;
   localparam int FLAG_PF     = 2;
   localparam int FLAG_AF     = 4;
   localparam int FLAG_ZF     = 6;
   localparam int FLAG_SF     = 7;
   localparam int FLAG_OF     = 11;

   // Width in bits of lane k (8, 16, 32)
   function automatic int lane_width(input int k);
      return 8 << k;
   endfunction

   // Lane index selected by a size code; code 3 aliases the widest lane
   function automatic logic [1:0] lane_of(input logic [1:0] sz);
      return (sz == SZ_WIDE) ? 2'd2 : sz;
   endfunction

endpackage

// File: rtl/mwalu_width_mask.sv
module mwalu_width_mask #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [1:0]        size_i,
   output logic [DATA_W-1:0] mask_o
);
   localparam int N_BYTES = DATA_W / LANE_W;

   generate
      for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
         logic en;
         if (k == 0) begin : g_low
            assign en = 1'b1;
         end else if (k == 1) begin : g_mid
            assign en = (size_i != 2'd0);
         end else begin : g_high
            assign en = size_i[1];
         end
         assign mask_o[k*LANE_W +: LANE_W] = {LANE_W{en}};
      end
   endgenerate

endmodule

// File: rtl/mwalu_carry_chain.sv
module mwalu_carry_chain #(
   parameter int DATA_W      = 32,
   parameter int ADDER_STYLE = 0,   // 0: per-bit ripple, 1: operator adder
   parameter int AUX_BIT     = 4,
   parameter int N_LANES     = 3
) (
   input  logic [DATA_W-1:0]  a_i,
   input  logic [DATA_W-1:0]  b_i,
   input  logic               cin_i,
   output logic [DATA_W-1:0]  sum_o,
   output logic               c_aux_o,      // carry into bit AUX_BIT
   output logic [N_LANES-1:0] c_sign_o,     // carry into top bit of lane
   output logic [N_LANES-1:0] c_out_o       // carry out of top bit of lane
);
   logic [DATA_W:0] carry;

   generate
      if (ADDER_STYLE == 0) begin : g_ripple
         assign carry[0] = cin_i;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            logic p;
            assign p          = a_i[i] ^ b_i[i];
            assign sum_o[i]   = p ^ carry[i];
            assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & p);
         end
      end else begin : g_operator
         logic [DATA_W:0] full;
         assign full      = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
         assign sum_o     = full[DATA_W-1:0];
         assign carry[0]  = cin_i;
         assign carry[DATA_W] = full[DATA_W];
         for (genvar i = 1; i < DATA_W; i++) begin : g_rec
            assign carry[i] = full[i] ^ a_i[i] ^ b_i[i];
         end
      end

      for (genvar k = 0; k < N_LANES; k++) begin : g_lane
         localparam int LW = 8 << k;
         assign c_sign_o[k] = carry[LW-1];
         assign c_out_o[k]  = carry[LW];
      end
   endgenerate

   assign c_aux_o = carry[AUX_BIT];

endmodule

// File: rtl/mwalu_logic_unit.sv
module mwalu_logic_unit #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        sel_i,   // 1 AND, 2 OR, 3 XOR
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);
   always_comb begin
      unique case (sel_i)
         2'd1:    y_o = a_i & b_i;
         2'd2:    y_o = a_i | b_i;
         2'd3:    y_o = a_i ^ b_i;
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/mwalu_flag_gen.sv
module mwalu_flag_gen
   import mwalu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int FLAGS_W   = 32,
   parameter int PARITY_W  = 8,
   parameter int N_LANES   = 3
) (
   input  logic [DATA_W-1:0]  res_i,      // already masked to the width
   input  logic [1:0]         lane_i,
   input  logic               arith_i,
   input  logic               sub_i,
   input  logic               c_aux_i,
   input  logic [N_LANES-1:0] c_sign_i,
   input  logic [N_LANES-1:0] c_out_i,
   input  logic [FLAGS_W-1:0] flags_q_i,
   output logic [FLAGS_W-1:0] flags_d_o
);
   logic [N_LANES-1:0] top_bit;
   logic cout, cinto, sf, zf, pf, cf, of, af;

   generate
      for (genvar k = 0; k < N_LANES; k++) begin : g_top
         assign top_bit[k] = res_i[(8 << k) - 1];
      end
   endgenerate

   always_comb begin
      cout  = c_out_i[lane_i];
      cinto = c_sign_i[lane_i];
      sf    = top_bit[lane_i];
      zf    = ~|res_i;
      pf    = ~^res_i[PARITY_W-1:0];
      if (arith_i) begin
         cf = cout ^ sub_i;
         of = cout ^ cinto;
         af = c_aux_i ^ sub_i;
      end else begin
         cf = 1'b0;
         of = 1'b0;
         af = flags_q_i[FLAG_AF];
      end
      flags_d_o          = flags_q_i;
      flags_d_o[FLAG_CF] = cf;
      flags_d_o[FLAG_PF] = pf;
      flags_d_o[FLAG_AF] = af;
      flags_d_o[FLAG_ZF] = zf;
      flags_d_o[FLAG_SF] = sf;
      flags_d_o[FLAG_OF] = of;
   end
endmodule

// File: rtl/mw_alu_flags.sv
module mw_alu_flags
   import mwalu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int FLAGS_W     = 32,
   parameter int ADDER_STYLE = 0,
   parameter int AUX_BIT     = 4,
   parameter int PARITY_W    = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        op_i,
   input  logic [1:0]        size_i,
   input  logic [31:0]       a_i,
   input  logic [31:0]       b_i,
   input  logic              carry_in_i,
   input  logic              upd_i,
   output logic [31:0]       result_o,
   output logic              res_we_o,
   output logic [31:0]       flags_o
);
   localparam logic [FLAGS_W-1:0] FLAGS_INIT = FLAGS_W'(1) << FLAG_ONE;

   generate
      if (DATA_W != 32) begin : g_chk_data
         $error("mw_alu_flags: DATA_W must be 32");
      end
      if (FLAGS_W != 32) begin : g_chk_flags
         $error("mw_alu_flags: FLAGS_W must be 32");
      end
      if (ADDER_STYLE < 0 || ADDER_STYLE > 1) begin : g_chk_style
         $error("mw_alu_flags: ADDER_STYLE must be 0 or 1");
      end
      if (AUX_BIT != 4 || PARITY_W != 8) begin : g_chk_pos
         $error("mw_alu_flags: AUX_BIT must be 4 and PARITY_W 8");
      end
   endgenerate

   alu_op_e           op;
   logic              is_arith, is_sub;
   logic              adder_cin;
   logic [DATA_W-1:0] b_eff, sum, logic_y, mask;
   logic              c_aux;
   logic [NUM_LANES-1:0] c_sign, c_out;
   logic [FLAGS_W-1:0] flags_q, flags_d;

   assign op       = alu_op_e'(op_i);
   assign is_arith = ~op_i[2] | (op == OP_CMP);
   assign is_sub   = (op == OP_SUB) | (op == OP_SBB) | (op == OP_CMP);
   assign b_eff    = is_sub ? ~b_i : b_i;

   always_comb begin
      unique case (op)
         OP_ADC:  adder_cin = carry_in_i;
         OP_SUB,
         OP_CMP:  adder_cin = 1'b1;
         OP_SBB:  adder_cin = ~carry_in_i;
         default: adder_cin = 1'b0;
      endcase
   end

   mwalu_width_mask #(.DATA_W(DATA_W), .LANE_W(8)) u_mask (
      .size_i (size_i),
      .mask_o (mask)
   );

   mwalu_carry_chain #(
      .DATA_W      (DATA_W),
      .ADDER_STYLE (ADDER_STYLE),
      .AUX_BIT     (AUX_BIT),
      .N_LANES     (NUM_LANES)
   ) u_chain (
      .a_i      (a_i),
      .b_i      (b_eff),
      .cin_i    (adder_cin),
      .sum_o    (sum),
      .c_aux_o  (c_aux),
      .c_sign_o (c_sign),
      .c_out_o  (c_out)
   );

   mwalu_logic_unit #(.DATA_W(DATA_W)) u_logic (
      .sel_i (op_i[1:0]),
      .a_i   (a_i),
      .b_i   (b_i),
      .y_o   (logic_y)
   );

   assign result_o = (is_arith ? sum : logic_y) & mask;
   assign res_we_o = (op != OP_CMP);

   mwalu_flag_gen #(
      .DATA_W   (DATA_W),
      .FLAGS_W  (FLAGS_W),
      .PARITY_W (PARITY_W),
      .N_LANES  (NUM_LANES)
   ) u_flags (
      .res_i     (result_o),
      .lane_i    (lane_of(size_i)),
      .arith_i   (is_arith),
      .sub_i     (is_sub),
      .c_aux_i   (c_aux),
      .c_sign_i  (c_sign),
      .c_out_i   (c_out),
      .flags_q_i (flags_q),
      .flags_d_o (flags_d)
   );

   always_ff @(posedge clk) begin
      if (rst)        flags_q <= FLAGS_INIT;
      else if (upd_i) flags_q <= flags_d;
   end

   assign flags_o = flags_q;

endmodule

// File: rtl/mwalu_checker.sv
module mwalu_checker (
   input logic        clk,
   input logic        rst,
   input logic [2:0]  op_i,
   input logic [1:0]  size_i,
   input logic        upd_i,
   input logic [31:0] result_o,
   input logic        res_we_o,
   input logic [31:0] flags_o
);
   AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
      (flags_o & ~32'h0000_08D5) == 32'h0000_0002); // R9

   AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
      !upd_i |=> $stable(flags_o)); // R10

   AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (upd_i && op_i >= 3'd5) |=> (!flags_o[0] && !flags_o[11])); // R8

   AST_LOGIC_KEEPS_AUX: assert property (@(posedge clk) disable iff (rst)
      (upd_i && op_i >= 3'd5) |=> $stable(flags_o[4])); // R8

   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (size_i == 2'd0) |-> (result_o[31:8] == 24'd0)); // R1

   AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (size_i == 2'd1) |-> (result_o[31:16] == 16'd0)); // R1

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'd4) |-> !res_we_o); // R2

   AST_PARITY_LOW: assert property (@(posedge clk) disable iff (rst)
      upd_i |=> (flags_o[2] == ~^$past(result_o[7:0]))); // R7

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      upd_i |=> (flags_o[6] == ($past(result_o) == 32'd0))); // R5
endmodule

bind mw_alu_flags mwalu_checker u_chk (
   .clk      (clk),
   .rst      (rst),
   .op_i     (op_i),
   .size_i   (size_i),
   .upd_i    (upd_i),
   .result_o (result_o),
   .res_we_o (res_we_o),
   .flags_o  (flags_o)
);

// File: tb/sim_mw_alu_flags.sv
module sim_mw_alu_flags;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  op_i = 3'd0;
   logic [1:0]  size_i = 2'd0;
   logic [31:0] a_i = 32'd0, b_i = 32'd0;
   logic        carry_in_i = 1'b0, upd_i = 1'b0;
   logic [31:0] result_o, flags_o;
   logic        res_we_o;

   int checks = 0, errors = 0;
   logic [31:0] mdl_flags = 32'h2;

   always #5 clk = ~clk;

   mw_alu_flags u0 (
      .clk(clk), .rst(rst), .op_i(op_i), .size_i(size_i), .a_i(a_i),
      .b_i(b_i), .carry_in_i(carry_in_i), .upd_i(upd_i),
      .result_o(result_o), .res_we_o(res_we_o), .flags_o(flags_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference of one operation
   function automatic void ref_op(input int op, input int sz, input logic [31:0] a,
                                  input logic [31:0] b, input bit cin,
                                  input logic [31:0] fin,
                                  output logic [31:0] res, output logic [31:0] fout);
      int w;
      longint m, ua, ub, full, r;
      bit cf, of, af, sa, sb, sr, c;
      w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
      m  = (longint'(1) << w) - 1;
      ua = longint'(a) & m;
      ub = longint'(b) & m;
      sa = ((ua >> (w - 1)) & 1) != 0;
      sb = ((ub >> (w - 1)) & 1) != 0;
      c  = 1'b0;
      if (op == 1 || op == 3) c = cin;
      cf = 0; of = 0; af = fin[4];
      if (op <= 1) begin
         full = ua + ub + longint'(c);
         r    = full & m;
         cf   = ((full >> w) & 1) != 0;
         af   = ((ua & 15) + (ub & 15) + longint'(c)) > 15;
         sr   = ((r >> (w - 1)) & 1) != 0;
         of   = (sa == sb) && (sr != sa);
      end else if (op <= 4) begin
         full = ua - ub - longint'(c);
         r    = full & m;
         cf   = full < 0;
         af   = ((ua & 15) - (ub & 15) - longint'(c)) < 0;
         sr   = ((r >> (w - 1)) & 1) != 0;
         of   = (sa != sb) && (sr != sa);
      end else begin
         if (op == 5)      r = ua & ub;
         else if (op == 6) r = ua | ub;
         else              r = ua ^ ub;
      end
      res     = r[31:0];
      fout    = fin;
      fout[0] = cf;
      fout[2] = ~^res[7:0];
      fout[4] = af;
      fout[6] = (res == 32'd0);
      fout[7] = res[w-1];
      fout[11] = of;
   endfunction

   task automatic check_flags();
      chk(flags_o[0] == mdl_flags[0], "R3 carry", flags_o, mdl_flags);
      chk(flags_o[11] == mdl_flags[11], "R4 overflow", flags_o, mdl_flags);
      chk(flags_o[7:6] == mdl_flags[7:6], "R5 sign/zero", flags_o, mdl_flags);
      chk(flags_o[4] == mdl_flags[4], "R6 auxiliary", flags_o, mdl_flags);
      chk(flags_o[2] == mdl_flags[2], "R7 parity", flags_o, mdl_flags);
      chk(flags_o == mdl_flags, "R9 whole word / R10 hold", flags_o, mdl_flags);
   endtask

   // One operation: checks prior flags, applies inputs, checks result
   task automatic step(input int op, input int sz, input logic [31:0] a,
                       input logic [31:0] b, input bit cin, input bit upd);
      logic [31:0] er, ef;
      @(negedge clk);
      check_flags();
      op_i = op[2:0]; size_i = sz[1:0]; a_i = a; b_i = b;
      carry_in_i = cin; upd_i = upd;
      #1;
      ref_op(op, sz, a, b, cin, mdl_flags, er, ef);
      if (op <= 1)      chk(result_o == er, "R1 add result", result_o, er);
      else if (op <= 4) chk(result_o == er, "R2 subtract result", result_o, er);
      else              chk(result_o == er, "R8 logic result", result_o, er);
      chk(res_we_o == (op != 4), "R2 write strobe", {31'd0, res_we_o},
          {31'd0, op != 4});
      @(posedge clk);
      if (upd) mdl_flags = ef;
   endtask

   function automatic logic [31:0] pick(input int k);
      case (k % 6)
         0: return 32'h0;
         1: return 32'hFFFF_FFFF;
         2: return 32'h7FFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'h0000_807F;
         default: return $urandom;
      endcase
   endfunction

   initial begin : watchdog
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(flags_o == 32'h2, "R9 reset value", flags_o, 32'h2);
      rst = 1'b0;
      // R1/R3/R6/R7: byte wrap sets carry, zero, aux, parity
      step(0, 0, 32'h0000_12FF, 32'h0000_0001, 0, 1);
      // R4: 16-bit signed overflow
      step(0, 1, 32'h0000_7FFF, 32'h0000_0001, 0, 1);
      // R1: add-with-carry at 32 bits
      step(1, 2, 32'hFFFF_FFFF, 32'h0000_0000, 1, 1);
      // R2/R3: 32-bit borrow
      step(2, 2, 32'h0, 32'h1, 0, 1);
      // R2: subtract-with-borrow, byte
      step(3, 0, 32'h0000_0010, 32'h0000_0001, 1, 1);
      // R2: compare sets flags, no write
      step(4, 1, 32'h0000_1234, 32'h0000_1234, 0, 1);
      // R6/R8: set aux, then logic keeps it
      step(0, 0, 32'h0F, 32'h01, 0, 1);
      step(5, 2, 32'hF0F0_F0F0, 32'hFFFF_0000, 0, 1);
      step(6, 0, 32'h1234_5600, 32'h0000_0003, 0, 1);
      step(7, 1, 32'hFFFF_AAAA, 32'h0000_AAAA, 0, 1);
      // R10: no update keeps flags
      step(2, 2, 32'h0, 32'h5, 0, 0);
      // size code 3 behaves as 32 bits
      step(0, 3, 32'h8000_0000, 32'h8000_0000, 0, 1);
      for (int i = 0; i < 3000; i++) begin
         step($urandom_range(0, 7), $urandom_range(0, 3), pick($urandom),
              pick($urandom), $urandom_range(0, 1), ($urandom_range(0, 3) != 0));
      end
      @(negedge clk);
      check_flags();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(flags_o == 32'h2, "R9 reset value again", flags_o, 32'h2);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule